// File: doc/BRIEF.md
# Serial Seven-Segment Display Controller

This block feeds an external eight-digit seven-segment display driver through a three-wire serial link: a data line, a bit clock, and an active-low load strobe. Every transfer is one 16-bit frame. The frame holds an 8-bit register address followed by 8 data bits. After reset the block sends a fixed series of configuration frames on its own. These frames turn the display test mode off, leave shutdown, enable all eight digits, enable the driver's decimal decode on every digit, and set the brightness.

Once configuration is done, the block takes a binary value on a one-cycle start pulse. It clamps the value to eight decimal digits and converts it to BCD with a sequential shift-and-add-3 converter. It then writes each decimal digit into the driver's own digit register. The busy output tells the host when a new value can be given. A divider parameter sets how many system clock cycles each half of the serial bit clock lasts.

Top module: `seg_serial_ctrl`

## Requirements
- R1: Each frame has 16 bits. The 8-bit register address is sent first and the 8-bit data second, each most significant bit first. A bit is valid on the rising edge of the serial clock.
- R2: The load strobe goes low before the first serial clock rising edge of a frame. It stays low for exactly 16 rising edges and returns high after the last one, which latches the frame.
- R3: The serial clock idles low. The data line changes only while the serial clock is low.
- R4: After reset the block sends five frames (address, data), in this order: (0x0F, 0x00), (0x0C, 0x01), (0x0B, 0x07), (0x09, 0xFF), (0x0A, BRIGHTNESS).
- R5: For each accepted value the block sends eight digit frames, with addresses 0x08 down to 0x01. Address 0x01 carries the least significant decimal digit and 0x08 the most significant. The data byte holds the digit in bits 3..0, and bits 7..4 are zero.
- R6: An input value above 99,999,999 is shown as 99,999,999: all eight digit frames carry 9.
- R7: busy is high from reset until the configuration frames are done. It is high from the cycle after an accepted start until the last digit frame has been latched. It is low otherwise.
- R8: A start pulse while busy is high is ignored. It causes no frames, and the value being shown is not changed.
- R9: When a frame ends, the serial clock and data lines are low and the load strobe is high.
- R10: Each high phase of the serial clock lasts exactly CLK_DIV system clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to display `value` |
| value | input | VAL_W | Binary value to display |
| busy | output | 1 | High while configuring or updating |
| ser_data | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial bit clock |
| ser_load_n | output | 1 | Active-low frame load strobe |

## Verification
The assertions assume the host raises start for a single cycle and that the system clock runs at least 2·CLK_DIV times faster than the link needs. They also assume reset is held for at least one clock before any start. The bench drives start and value only on falling clock edges and holds start for exactly one cycle. It gives a new value only after it sees busy low. The single exception is the deliberate start pulse while busy is high, which checks the ignore rule. That pulse lies well inside a running update.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int FRAME_W = 16;
  localparam int CFG_N   = 5;

  typedef enum logic [1:0] {TX_IDLE, TX_LOW, TX_HIGH, TX_GAP} tx_state_t;
  typedef enum logic [1:0] {SQ_CFG, SQ_IDLE, SQ_CONV, SQ_SEND} seq_state_t;

  function automatic logic [FRAME_W-1:0] cfg_frame(input logic [2:0] idx,
                                                   input logic [7:0] bright);
    case (idx)
      3'd0:    cfg_frame = {8'h0F, 8'h00};
      3'd1:    cfg_frame = {8'h0C, 8'h01};
      3'd2:    cfg_frame = {8'h0B, 8'h07};
      3'd3:    cfg_frame = {8'h09, 8'hFF};
      default: cfg_frame = {8'h0A, bright};
    endcase
  endfunction
endpackage

// File: rtl/seg_frame_tx.sv
module seg_frame_tx
  import seg_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [FRAME_W-1:0] frame,
  output logic               ready,
  output logic               done,
  output logic               sdat,
  output logic               sclk,
  output logic               load_n
);
  localparam int CW = $clog2(CLK_DIV + 1);
  localparam int BW = $clog2(FRAME_W);

  tx_state_t          st;
  logic [CW-1:0]      cnt;
  logic [BW-1:0]      bitn;
  logic [FRAME_W-1:0] sreg;
  logic               phase_end;

  assign phase_end = (cnt == CW'(CLK_DIV - 1));
  assign ready     = (st == TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= TX_IDLE; cnt <= '0; bitn <= '0; sreg <= '0;
      sdat <= 1'b0; sclk <= 1'b0; load_n <= 1'b1; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        TX_IDLE: if (go) begin
          sreg <= frame; sdat <= frame[FRAME_W-1];
          load_n <= 1'b0; cnt <= '0; bitn <= '0; st <= TX_LOW;
        end
        TX_LOW: begin
          if (phase_end) begin cnt <= '0; sclk <= 1'b1; st <= TX_HIGH; end
          else cnt <= cnt + 1'b1;
        end
        TX_HIGH: begin
          if (phase_end) begin
            cnt <= '0; sclk <= 1'b0;
            if (bitn == BW'(FRAME_W - 1)) begin
              load_n <= 1'b1; sdat <= 1'b0; st <= TX_GAP;
            end else begin
              bitn <= bitn + 1'b1;
              sreg <= {sreg[FRAME_W-2:0], 1'b0};
              sdat <= sreg[FRAME_W-2];
              st   <= TX_LOW;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (phase_end) begin cnt <= '0; done <= 1'b1; st <= TX_IDLE; end
          else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  // R3
  data_stable_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdat));
  // R2
  clk_only_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !load_n);
  // R9
  idle_lines_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(load_n) |-> (!sclk && !sdat));
endmodule

// File: rtl/seg_bin2bcd.sv
module seg_bin2bcd #(
  parameter int BIN_W  = 32,
  parameter int DIGITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic [BIN_W-1:0]    bin,
  output logic [4*DIGITS-1:0] bcd,
  output logic                done
);
  localparam int BCD_W = 4 * DIGITS;
  localparam int CNT_W = $clog2(BIN_W + 1);

  logic [BIN_W-1:0] sh;
  logic [BCD_W-1:0] adj;
  logic [CNT_W-1:0] cnt;
  logic             run;

  for (genvar d = 0; d < DIGITS; d++) begin : g_adj
    assign adj[4*d +: 4] = (bcd[4*d +: 4] >= 4'd5) ? bcd[4*d +: 4] + 4'd3
                                                   : bcd[4*d +: 4];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0; bcd <= '0; cnt <= '0; run <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !run) begin
        sh <= bin; bcd <= '0; cnt <= CNT_W'(BIN_W); run <= 1'b1;
      end else if (run) begin
        bcd <= {adj[BCD_W-2:0], sh[BIN_W-1]};
        sh  <= {sh[BIN_W-2:0], 1'b0};
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin run <= 1'b0; done <= 1'b1; end
      end
    end
  end
endmodule

// File: rtl/seg_serial_ctrl.sv
module seg_serial_ctrl
  import seg_pkg::*;
#(
  parameter int          VAL_W      = 32,
  parameter int          DIGITS     = 8,
  parameter int          CLK_DIV    = 4,
  parameter logic [7:0]  BRIGHTNESS = 8'h04
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [VAL_W-1:0] value,
  output logic             busy,
  output logic             ser_data,
  output logic             ser_clk,
  output logic             ser_load_n
);
  localparam longint      MAX_VAL = 64'd99999999;
  localparam logic [2:0]  LAST_CFG = 3'(CFG_N - 1);
  localparam logic [2:0]  LAST_DIG = 3'(DIGITS - 1);

  seq_state_t          st;
  logic [2:0]          idx;
  logic                issued, go;
  logic                conv_go, conv_done;
  logic [VAL_W-1:0]    val_q;
  logic [4*DIGITS-1:0] bcd, dig_q;
  logic [FRAME_W-1:0]  frame_q, next_frame;
  logic                tx_ready, tx_done;
  logic [VAL_W-1:0]    sat_val;

  assign sat_val = (64'(value) > MAX_VAL) ? VAL_W'(MAX_VAL) : value;

  always_comb begin
    if (st == SQ_CFG) next_frame = cfg_frame(idx, BRIGHTNESS);
    else next_frame = {8'(DIGITS) - 8'(idx),
                       4'h0, dig_q[4*(DIGITS-1-32'(idx)) +: 4]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SQ_CFG; idx <= '0; issued <= 1'b0; go <= 1'b0; busy <= 1'b1;
      conv_go <= 1'b0; val_q <= '0; dig_q <= '0; frame_q <= '0;
    end else begin
      go <= 1'b0; conv_go <= 1'b0;
      case (st)
        SQ_IDLE: if (start) begin
          val_q <= sat_val; conv_go <= 1'b1; busy <= 1'b1; st <= SQ_CONV;
        end
        SQ_CONV: if (conv_done) begin dig_q <= bcd; idx <= '0; st <= SQ_SEND; end
        default: begin
          if (!issued && tx_ready && !go) begin
            go <= 1'b1; issued <= 1'b1; frame_q <= next_frame;
          end
          if (tx_done) begin
            issued <= 1'b0;
            if (idx == ((st == SQ_CFG) ? LAST_CFG : LAST_DIG)) begin
              idx <= '0; busy <= 1'b0; st <= SQ_IDLE;
            end else idx <= idx + 1'b1;
          end
        end
      endcase
    end
  end

  seg_bin2bcd #(.BIN_W(VAL_W), .DIGITS(DIGITS)) u_conv (
    .clk(clk), .rst(rst), .go(conv_go), .bin(val_q), .bcd(bcd), .done(conv_done)
  );

  seg_frame_tx #(.CLK_DIV(CLK_DIV)) u_tx (
    .clk(clk), .rst(rst), .go(go), .frame(frame_q), .ready(tx_ready),
    .done(tx_done), .sdat(ser_data), .sclk(ser_clk), .load_n(ser_load_n)
  );

  // R7
  busy_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R8
  ignore_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> $stable(val_q));
  // R7
  idle_no_traffic_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ser_load_n);
endmodule

// File: tb/seg_serial_ctrl_tb.sv
module seg_serial_ctrl_tb;
  localparam int CLK_DIV = 2;
  localparam logic [7:0] BRIGHT = 8'h04;

  logic clk = 0, rst = 1, start = 0;
  logic [31:0] value = '0;
  logic busy, ser_data, ser_clk, ser_load_n;
  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  seg_serial_ctrl #(.VAL_W(32), .DIGITS(8), .CLK_DIV(CLK_DIV), .BRIGHTNESS(BRIGHT)) u_dut (
    .clk(clk), .rst(rst), .start(start), .value(value), .busy(busy),
    .ser_data(ser_data), .ser_clk(ser_clk), .ser_load_n(ser_load_n)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push_value(input longint v);
    longint s = (v > 99999999) ? 99999999 : v;
    longint p;
    for (int k = 8; k >= 1; k--) begin
      p = 1;
      for (int j = 1; j < k; j++) p = p * 10;
      exp_q.push_back({8'(k), 8'((s / p) % 10)});
      tag_q.push_back((v > 99999999) ? "R6" : "R5");
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic send_value(input longint v, input bit poke_busy);
    wait_idle();
    push_value(v);
    value = 32'(v); start = 1;
    @(negedge clk); start = 0;
    check(busy === 1'b1, "R7 busy after start", busy, 1);
    if (poke_busy) begin
      repeat (20) @(negedge clk);
      value = 32'd55555555; start = 1;   // R8 ignored request
      @(negedge clk); start = 0;
    end
    wait_idle();
    check(exp_q.size() == 0, "R7 busy fell before all frames", exp_q.size(), 0);
  endtask

  // scoreboard monitor
  logic p_clk = 0, p_load = 1, p_dat = 0;
  logic [15:0] shreg;
  int nbits, hi_cnt;
  bit stab_ok, rate_ok;
  always @(negedge clk) begin
    if (!rst) begin
      if (p_load && !ser_load_n) begin nbits = 0; stab_ok = 1; rate_ok = 1; end
      if (!p_clk && ser_clk) begin
        shreg = {shreg[14:0], ser_data}; nbits++; hi_cnt = 1;
      end else if (ser_clk) begin
        hi_cnt++;
        if (ser_data !== p_dat) stab_ok = 0;
      end
      if (p_clk && !ser_clk && hi_cnt != CLK_DIV) rate_ok = 0;
      if (!p_load && ser_load_n) begin
        check(nbits == 16, "R2 rising edges per frame", nbits, 16);
        check(stab_ok, "R3 data moved while clock high", 0, 1);
        check(rate_ok, "R10 high phase length", hi_cnt, CLK_DIV);
        check(!ser_clk && !ser_data, "R9 lines after frame", {ser_clk, ser_data}, 0);
        check(busy === 1'b1, "R7 busy at latch", busy, 1);
        if (exp_q.size() == 0) check(0, "R8 unexpected frame", shreg, 0);
        else begin
          automatic logic [15:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(shreg == e, {t, " R1 frame"}, shreg, e);
        end
      end
    end
    p_clk = ser_clk; p_load = ser_load_n; p_dat = ser_data;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(ser_load_n === 1'b1 && ser_clk === 1'b0, "R9 reset lines", {ser_load_n, ser_clk}, 2);
    check(busy === 1'b1, "R7 busy in reset", busy, 1);
    exp_q.push_back(16'h0F00); tag_q.push_back("R4");
    exp_q.push_back(16'h0C01); tag_q.push_back("R4");
    exp_q.push_back(16'h0B07); tag_q.push_back("R4");
    exp_q.push_back(16'h09FF); tag_q.push_back("R4");
    exp_q.push_back({8'h0A, BRIGHT}); tag_q.push_back("R4");
    rst = 0;
    @(negedge clk);
    check(busy === 1'b1, "R7 busy during config", busy, 1);
    wait_idle();
    check(exp_q.size() == 0, "R4 config done before idle", exp_q.size(), 0);
    send_value(12345678, 0);
    send_value(0, 0);
    send_value(99999999, 1);
    send_value(100000000, 0);
    send_value(32'hFFFF_FFFF, 0);
    send_value(7, 1);
    send_value(90817263, 0);
    repeat (50) @(negedge clk);
    check(ser_load_n === 1'b1 && exp_q.size() == 0, "R8 no stray frames", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule